// File: doc/BRIEF.md
# Double-Data-Rate Lane Deserializer with Frame Alignment

This block receives a group of serial sample lanes that all run off one shared bit clock and one shared frame signal. Each lane carries one bit on the rising edge and one on the falling edge of the bit clock. The frame signal is captured by the same two-edge logic as the data, so it is treated as one more lane. Its low-to-high transitions mark where each word begins. A small tracker checks that these boundaries keep arriving at a fixed spacing and bit phase. It declares alignment only after several good frames in a row, and it drops alignment on the first irregular frame.

Two configuration inputs match the receiver to the transmitter. One selects the word length: 8, 10, 12 or 14 bits. The other selects whether each word arrives most-significant bit first or least-significant bit first. Every lane produces a right-justified parallel word in a fixed bit order. The words of all lanes update together with a single one-cycle valid strobe, once per frame, and only while aligned. A repeated test word (a single high bit at the top of the word, then zeros) can be sent on every lane to confirm lane and bit alignment.

The tracker has three states:
- SEARCH: no boundary has been seen yet.
- TRACK: a reference boundary is held and good frames are being counted.
- LOCKED: the block is aligned.

The transitions are:
- SEARCH goes to TRACK on any boundary.
- TRACK counts each good boundary. It goes to LOCKED on the fourth good boundary. A misplaced boundary keeps it in TRACK with that boundary as the new reference and the count cleared. A missing boundary sends it back to SEARCH.
- LOCKED stays on a good boundary. It goes to TRACK on a misplaced boundary and to SEARCH on a missing boundary.

Top module: `ddr_lane_deser`

## Requirements
- R1: Each lane and the frame input are sampled on both bit-clock edges. Within one bit-clock period, the bit sampled at the rising edge precedes the bit sampled at the following falling edge in the serial stream.
- R2: A word boundary is the bit at which the sampled frame value goes from 0 to 1. The boundary may fall on either the rising-edge or the falling-edge bit of a clock period.
- R3: The word-length select codes 0, 1, 2 and 3 choose 8, 10, 12 and 14 bits. Each lane's word is right-justified in its 14-bit output field (lane i in bits i*14 upward), and the bits above the word length read 0.
- R4: With the bit-order input at 1, the first bit after a boundary is the word's most significant bit. With it at 0, the first bit is the least significant bit.
- R5: After the first boundary (the reference), lock is declared when 4 further boundaries in a row each arrive exactly one word length later and on the same clock edge. The lock output rises one cycle after the fourth of these boundaries.
- R6: The valid strobe is a one-cycle pulse raised only while locked. It appears at each good boundary after lock and carries the word that this boundary completes. Between strobes the word outputs hold their value. A burst of n frames therefore yields n-5 strobes.
- R7: A boundary at the wrong spacing or on the wrong edge, or a missing boundary, drops the lock output at once. When this happens while locked, the loss flag pulses for one cycle.
- R8: After a loss, no word is strobed until 4 fresh good boundaries have followed a new reference boundary.
- R9: The asynchronous reset clears the capture registers, the word outputs and the lock state. The lock output and the valid strobe read 0 during reset and until lock is reached again.
- R10: The test word with only its top bit set, sent on every lane, is delivered unchanged on every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock; data and frame are sampled on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_d | input | NLANES | Serial data, one bit per lane |
| frame_in | input | 1 | Frame signal, high for the first half of each word |
| wlen_sel | input | 2 | Word length select: 0=8, 1=10, 2=12, 3=14 bits |
| msb_first | input | 1 | 1: words arrive most significant bit first; 0: least significant bit first |
| words_o | output | NLANES*MAXW | Parallel words, lane i in bits [i*MAXW +: MAXW] |
| word_valid | output | 1 | One-cycle strobe marking a new set of words |
| locked | output | 1 | Alignment has been reached |
| align_lost | output | 1 | One-cycle pulse when alignment is lost |

## Verification
An off-by-one in the boundary spacing or a wrong edge phase shows up within one frame as a rotated or bit-shifted word on every lane. It also stops the strobe, because the lock never forms. A lock counter that is off by one changes the number of strobes in each burst away from n-5, and the lock output rises one frame early or late. A stuck loss detector leaves the lock output high after the frame signal goes quiet, which is visible about half a word later. A history shift or a bit reversal that is wrong corrupts only certain word lengths or bit orders. This is why the stimulus sweeps all four lengths, both orders and both boundary phases.

// File: rtl/ddr_lane_pkg.sv
`timescale 1ns/1ps
package ddr_lane_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_TRACK  = 2'd1,
        ST_LOCKED = 2'd2
    } trk_state_t;

    // Word length in bits for a select code: 8, 10, 12 or 14.
    function automatic int word_bits(input logic [1:0] sel);
        return 8 + 2 * int'(sel);
    endfunction

endpackage

// File: rtl/ddr_edge_capture.sv
`timescale 1ns/1ps
module ddr_edge_capture #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise_q,
    output logic [N-1:0] fall_q
);

    // Rising-edge bit of a period; paired with the falling-edge bit that follows it (R1).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= din;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= din;
    end

endmodule

// File: rtl/ddr_frame_tracker.sv
`timescale 1ns/1ps
module ddr_frame_tracker
    import ddr_lane_pkg::*;
#(
    parameter int MAXW        = 14,
    parameter int LOCK_FRAMES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fr_rise,
    input  logic       fr_fall,
    input  logic [1:0] wlen_sel,
    output logic       capture_en,
    output logic       cap_phase,
    output logic       word_valid,
    output logic       locked,
    output logic       align_lost
);

    localparam int CW = $clog2(MAXW);
    localparam int GW = $clog2(LOCK_FRAMES + 1);

    trk_state_t      state_q, state_d;
    logic            fr_last_q;
    logic [CW-1:0]   cyc_q;
    logic            ref_q;
    logic [GW-1:0]   good_q;

    int   half;
    logic rise0, rise1, rise_any;
    logic good, miss;

    always_comb begin
        half     = word_bits(wlen_sel) / 2;
        rise0    = !fr_last_q && fr_rise;          // boundary on rising-edge bit (R2)
        rise1    = !fr_rise && fr_fall;            // boundary on falling-edge bit (R2)
        rise_any = rise0 || rise1;
        good     = rise_any && (rise1 == ref_q) && (int'(cyc_q) == half - 1);
        miss     = !rise_any && (int'(cyc_q) >= half - 1);
    end

    assign capture_en = (state_q == ST_LOCKED) && good;
    assign cap_phase  = rise1;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEARCH: begin
                if (rise_any) state_d = ST_TRACK;
            end
            ST_TRACK: begin
                if (good) begin
                    if (int'(good_q) == LOCK_FRAMES - 1) state_d = ST_LOCKED;
                end else if (miss) begin
                    state_d = ST_SEARCH;
                end
            end
            ST_LOCKED: begin
                if (rise_any && !good) state_d = ST_TRACK;
                else if (miss)         state_d = ST_SEARCH;
            end
            default: state_d = ST_SEARCH;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEARCH;
        else        state_q <= state_d;
    end

    // Boundary bookkeeping: last frame bit, spacing counter, reference phase, good count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_last_q <= 1'b0;
            cyc_q     <= '0;
            ref_q     <= 1'b0;
            good_q    <= '0;
        end else begin
            fr_last_q <= fr_fall;
            if (rise_any) begin
                cyc_q  <= '0;
                ref_q  <= rise1;
                good_q <= (good && state_q == ST_TRACK) ? good_q + 1'b1 : '0;
            end else if (cyc_q != {CW{1'b1}}) begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            locked     <= 1'b0;
            align_lost <= 1'b0;
        end else begin
            word_valid <= capture_en;
            locked     <= (state_d == ST_LOCKED);
            align_lost <= (state_q == ST_LOCKED) && (state_d != ST_LOCKED);
        end
    end

    assert_valid_when_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> locked);

    assert_valid_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_loss_clears_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        align_lost |-> !locked);

    assert_lock_from_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(state_q) == ST_TRACK));

    assert_lock_after_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (int'($past(good_q)) == LOCK_FRAMES - 1));

endmodule

// File: rtl/ddr_word_assembler.sv
`timescale 1ns/1ps
module ddr_word_assembler
    import ddr_lane_pkg::*;
#(
    parameter int MAXW = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_r,
    input  logic            bit_f,
    input  logic            capture_en,
    input  logic            cap_phase,
    input  logic [1:0]      wlen_sel,
    input  logic            msb_first,
    output logic [MAXW-1:0] word_o
);

    logic [MAXW-1:0] hist_q;
    logic [MAXW:0]   ext;
    logic [MAXW-1:0] raw, full_rev, rev;
    int              wlen;

    // Oldest bit at the highest index; the falling-edge bit of the current
    // pair never belongs to the finished word, so it is left out here.
    assign ext  = {hist_q, bit_r};
    assign wlen = word_bits(wlen_sel);

    for (genvar j = 0; j < MAXW; j++) begin : g_bit
        assign raw[j]      = (j < wlen) ? (cap_phase ? ext[j] : ext[j+1]) : 1'b0;
        assign full_rev[j] = raw[MAXW-1-j];
    end

    assign rev = full_rev >> (MAXW - wlen);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            word_o <= '0;
        end else begin
            hist_q <= {hist_q[MAXW-3:0], bit_r, bit_f};
            if (capture_en) word_o <= msb_first ? raw : rev;
        end
    end

endmodule

// File: rtl/ddr_lane_deser.sv
`timescale 1ns/1ps
module ddr_lane_deser
    import ddr_lane_pkg::*;
#(
    parameter int NLANES      = 4,
    parameter int MAXW        = 14,
    parameter int LOCK_FRAMES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NLANES-1:0]      lane_d,
    input  logic                   frame_in,
    input  logic [1:0]             wlen_sel,
    input  logic                   msb_first,
    output logic [NLANES*MAXW-1:0] words_o,
    output logic                   word_valid,
    output logic                   locked,
    output logic                   align_lost
);

    localparam int NCAP = NLANES + 1;   // frame captured as an extra lane

    logic [NCAP-1:0] rise_q, fall_q;
    logic            capture_en, cap_phase;

    ddr_edge_capture #(.N(NCAP)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    ({frame_in, lane_d}),
        .rise_q (rise_q),
        .fall_q (fall_q)
    );

    ddr_frame_tracker #(.MAXW(MAXW), .LOCK_FRAMES(LOCK_FRAMES)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .fr_rise    (rise_q[NLANES]),
        .fr_fall    (fall_q[NLANES]),
        .wlen_sel   (wlen_sel),
        .capture_en (capture_en),
        .cap_phase  (cap_phase),
        .word_valid (word_valid),
        .locked     (locked),
        .align_lost (align_lost)
    );

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        ddr_word_assembler #(.MAXW(MAXW)) u_asm (
            .clk        (clk),
            .rst_n      (rst_n),
            .bit_r      (rise_q[i]),
            .bit_f      (fall_q[i]),
            .capture_en (capture_en),
            .cap_phase  (cap_phase),
            .wlen_sel   (wlen_sel),
            .msb_first  (msb_first),
            .word_o     (words_o[i*MAXW +: MAXW])
        );
    end

    assert_words_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(words_o));

endmodule

// File: tb/ddr_lane_deser_tb.sv
`timescale 1ns/1ps
module ddr_lane_deser_tb;

    localparam int NL = 4;
    localparam int MW = 14;
    localparam int LONG_GAP = 2 * MW + 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NL-1:0]     lane_d;
    logic              frame_in;
    logic [1:0]        wlen_sel;
    logic              msb_first;
    logic [NL*MW-1:0]  words_o;
    logic              word_valid, locked, align_lost;

    int n_tests = 0, n_fail = 0;
    int n_valid = 0, n_lost = 0;
    bit done = 0;
    logic [NL*MW-1:0] exp_q[$];

    always #5 clk = ~clk;   // 100 MHz

    ddr_lane_deser u_dut (
        .clk(clk), .rst_n(rst_n), .lane_d(lane_d), .frame_in(frame_in),
        .wlen_sel(wlen_sel), .msb_first(msb_first), .words_o(words_o),
        .word_valid(word_valid), .locked(locked), .align_lost(align_lost)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Output monitor: each strobe is compared with the next expected word set (R3 R4 R6).
    always @(posedge clk) begin
        #1;
        if (rst_n === 1'b1) begin
            if (align_lost) n_lost++;
            if (word_valid) begin
                n_valid++;
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "unexpected strobe", 64'(words_o), 64'h0);
                end else begin
                    logic [NL*MW-1:0] e;
                    e = exp_q.pop_front();
                    for (int l = 0; l < NL; l++)
                        chk(words_o[l*MW +: MW] == e[l*MW +: MW], "R3/R4",
                            $sformatf("lane %0d word", l),
                            64'(words_o[l*MW +: MW]), 64'(e[l*MW +: MW]));
                end
            end
        end
    end

    // One serial bit on every lane: set just after an edge, sampled at the next (R1).
    task automatic emit(input logic fr, input logic [NL-1:0] d);
        @(posedge clk or negedge clk);
        #2;
        frame_in = fr;
        lane_d   = d;
    endtask

    function automatic logic [MW-1:0] gen_word(input int mode, input int w);
        logic [MW-1:0] v, mask;
        mask = MW'((1 << w) - 1);
        case (mode)
            0:       v = MW'($urandom);
            1:       v = MW'(1 << (w - 1));    // test word: top bit only (R10)
            2:       v = '1;
            default: v = MW'(14'h2AAA);
        endcase
        return v & mask;
    endfunction

    task automatic send_burst(input int n, input logic [1:0] sel, input logic msb,
                              input int mode, input int gap, input int exp_lost,
                              input bit quiet_end);
        int w;
        logic [NL*MW-1:0] wv;
        logic [NL-1:0] d;
        w = 8 + 2 * int'(sel);
        n_valid = 0;
        n_lost  = 0;
        wlen_sel  = sel;
        msb_first = msb;
        for (int k = 0; k < n; k++) begin
            wv = '0;
            for (int l = 0; l < NL; l++) wv[l*MW +: MW] = gen_word(mode, w);
            if (k >= 4 && k <= n - 2) exp_q.push_back(wv);
            for (int b = 0; b < w; b++) begin
                int idx;
                idx = msb ? (w - 1 - b) : b;
                for (int l = 0; l < NL; l++) d[l] = wv[l*MW + idx];
                emit(b < w / 2, d);
            end
            if (k == 3 && n >= 8) chk(locked == 1'b0, "R5", "locked before 4 good frames", 64'(locked), 64'h0);
            if (k == 6 && n >= 8) chk(locked == 1'b1, "R5", "locked after 4 good frames", 64'(locked), 64'h1);
        end
        for (int g = 0; g < gap; g++) emit(1'b0, '0);
        chk(n_valid == ((n > 5) ? n - 5 : 0), "R6", "strobe count", 64'(n_valid), 64'((n > 5) ? n - 5 : 0));
        chk(exp_q.size() == 0, "R6", "missing strobes", 64'(exp_q.size()), 64'h0);
        chk(n_lost == exp_lost, "R7", "loss pulses", 64'(n_lost), 64'(exp_lost));
        if (quiet_end) chk(locked == 1'b0, "R7", "lock after quiet frame line", 64'(locked), 64'h0);
        exp_q.delete();
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        rst_n = 1'b0; lane_d = '0; frame_in = 1'b0; wlen_sel = 2'd0; msb_first = 1'b1;
        #23;
        // R9: reset state
        chk(locked == 1'b0, "R9", "locked in reset", 64'(locked), 64'h0);
        chk(word_valid == 1'b0, "R9", "valid in reset", 64'(word_valid), 64'h0);
        chk(words_o == '0, "R9", "words in reset", 64'(words_o[63:0]), 64'h0);
        rst_n = 1'b1;

        // R3 R4: every length in both orders
        send_burst(10, 2'd0, 1'b1, 0, LONG_GAP,     1, 1);
        send_burst(9,  2'd0, 1'b0, 0, LONG_GAP,     1, 1);
        send_burst(8,  2'd1, 1'b1, 3, LONG_GAP + 1, 1, 1);
        send_burst(8,  2'd2, 1'b0, 0, LONG_GAP,     1, 1);
        send_burst(9,  2'd3, 1'b1, 2, LONG_GAP + 1, 1, 1);
        send_burst(8,  2'd3, 1'b0, 0, LONG_GAP,     1, 1);

        // R10: test word on all lanes, both orders
        send_burst(7, 2'd0, 1'b1, 1, LONG_GAP, 1, 1);
        send_burst(7, 2'd0, 1'b0, 1, LONG_GAP, 1, 1);

        // R5 boundary: too few frames never lock; exactly five lock with no strobe
        send_burst(4, 2'd1, 1'b1, 0, LONG_GAP, 0, 1);
        send_burst(5, 2'd1, 1'b1, 0, LONG_GAP, 1, 1);

        // R2 R7 R8: one-bit slip moves the boundary to the other edge; loss, then fresh lock
        send_burst(9, 2'd2, 1'b1, 0, 1,        0, 0);
        send_burst(9, 2'd2, 1'b1, 0, LONG_GAP, 2, 1);

        // R2: constrained random lengths, orders, patterns and boundary phases
        for (int it = 0; it < 10; it++) begin
            logic [1:0] s;
            s = 2'($urandom % 4);
            send_burst(6 + int'($urandom % 7), s, 1'($urandom % 2), int'($urandom % 4),
                       LONG_GAP + int'($urandom % 2), 1, 1);
        end

        // R9: asynchronous reset while locked
        send_burst(8, 2'd0, 1'b1, 0, 0, 0, 0);
        chk(locked == 1'b1, "R9", "locked before reset", 64'(locked), 64'h1);
        rst_n = 1'b0;
        lane_d = '0; frame_in = 1'b0;
        #1;
        chk(locked == 1'b0, "R9", "locked cleared by reset", 64'(locked), 64'h0);
        chk(words_o == '0, "R9", "words cleared by reset", 64'(words_o[63:0]), 64'h0);
        chk(word_valid == 1'b0, "R9", "valid cleared by reset", 64'(word_valid), 64'h0);
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        send_burst(8, 2'd1, 1'b0, 0, LONG_GAP, 1, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule